// File: doc/BRIEF.md
# Single-Precision to Signed Integer Converter

This unit turns a 32-bit IEEE-754 binary32 operand into a signed integer that is either 32 or 64 bits wide. The caller picks one of four directed roundings for each conversion. The result is written to a 64-bit output one clock after the request. Word results are sign-extended into that output.

Each conversion also produces four exception flags: invalid, overflow, underflow and inexact. These flags are ORed into a sticky flag register. The register holds its bits until reset or until a software-style flag write replaces it. Any conversion marked invalid returns a fixed sentinel code in place of the computed integer. This lets a consumer detect a failed conversion from the data alone.

The unit takes one request per cycle and never stalls. There is no trap or handler hand-off: it only records flags and substitutes the sentinel.

Top module: `f2i_conv`

## Requirements
- R1: A request on `valid_i` raises `valid_o` for exactly one cycle at the clock edge that captures the request. `valid_o` is low in every other cycle.
- R2: Operation code 0 truncates toward zero. Example: -1.75 gives -1.
- R3: Operation code 1 rounds to the nearest integer. An exact halfway value goes to the even neighbour: 2.5 gives 2, 3.5 gives 4, -2.5 gives -2, 0.5 gives 0.
- R4: Operation code 2 rounds toward minus infinity, so -1.25 gives -2. Operation code 3 rounds toward plus infinity, so 1.25 gives 2 and -0.25 gives 0.
- R5: An operand whose exponent field is all ones (NaN or infinity) sets the invalid flag (bit 3). It sets no other new flag, and the result is the sentinel.
- R6: A rounded value outside the signed range of the selected width sets both the overflow flag (bit 2) and the invalid flag (bit 3), and the result is the sentinel. The lowest value, -2^31 for word or -2^63 for long, is still valid.
- R7: The inexact flag (bit 0) is raised exactly when a finite, in-range rounded value differs from the operand.
- R8: The underflow flag (bit 1) is never raised by a conversion. This includes subnormal operands, because a nonzero integer result is never below the smallest normal magnitude.
- R9: Flags are sticky. New flags are ORed into the register. When `flag_we_i` is high, `flag_wdata_i` replaces the register, and the flags of a conversion in that same cycle are ORed on top.
- R10: During reset, `valid_o`, `result_o` and `flags_o` are all zero.
- R11: With `long_i` low, the 32-bit result is sign-extended to 64 bits and the sentinel is 0x000000007FFFFFFF. With `long_i` high, the sentinel is 0x7FFFFFFFFFFFFFFF.
- R12: `result_o` keeps its value in cycles without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Conversion request |
| operand_i | input | 32 | binary32 operand |
| op_i | input | 2 | Rounding: 0 truncate, 1 nearest-even, 2 floor, 3 ceiling |
| long_i | input | 1 | 1 selects a 64-bit result, 0 a 32-bit result |
| flag_we_i | input | 1 | Replace the flag register |
| flag_wdata_i | input | 4 | Flag write data {invalid, overflow, underflow, inexact} |
| valid_o | output | 1 | Result valid pulse |
| result_o | output | 64 | Converted integer or sentinel |
| flags_o | output | 4 | Sticky flags {invalid, overflow, underflow, inexact} |

## Verification
A flag write and a conversion can land on the same clock edge. In that case the written value must become the new base and the conversion's flags must still be ORed onto it. The bench provokes this on purpose in two ways. It clears the register while converting an inexact value, and it writes a pattern while converting a NaN. It also mixes random writes into the random conversion stream. In each case the flag output one cycle later is compared with the written data ORed with the flags the bench model predicts for that operand.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;
  localparam int EXP_W    = 8;
  localparam int MAN_W    = 23;
  localparam int OUT_W    = 64;
  localparam int NARROW_W = 32;
  localparam int FLAG_W   = 4;

  localparam int FLAG_NX = 0;
  localparam int FLAG_UF = 1;
  localparam int FLAG_OF = 2;
  localparam int FLAG_NV = 3;

  typedef enum logic [1:0] {
    OP_TRUNC = 2'd0,
    OP_NEAR  = 2'd1,
    OP_FLOOR = 2'd2,
    OP_CEIL  = 2'd3
  } rnd_op_e;
endpackage

// File: rtl/f2i_align.sv
`timescale 1ns/1ps
// Splits the operand into integer magnitude, round bit and sticky bit.
module f2i_align #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int OUT_W = 64
) (
  input  logic [EXP_W+MAN_W:0] operand_i,
  output logic                 sign_o,
  output logic                 special_o,
  output logic                 huge_o,
  output logic [OUT_W-1:0]     int_o,
  output logic                 rnd_o,
  output logic                 sticky_o
);
  localparam int SIG_W = MAN_W + 1;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0]   exp_f;
  logic [MAN_W-1:0]   man_f;
  logic [SIG_W-1:0]   sig;
  logic [2*SIG_W-1:0] wide;
  int                 unb;

  assign sign_o    = operand_i[EXP_W+MAN_W];
  assign exp_f     = operand_i[MAN_W +: EXP_W];
  assign man_f     = operand_i[MAN_W-1:0];
  assign sig       = {1'b1, man_f};
  assign special_o = &exp_f;
  assign unb       = int'(exp_f) - BIAS;

  always_comb begin
    int_o    = '0;
    rnd_o    = 1'b0;
    sticky_o = 1'b0;
    huge_o   = 1'b0;
    wide     = '0;
    if (special_o) begin
      int_o = '0;
    end else if (exp_f == '0) begin
      sticky_o = |man_f;  // subnormal: far below one half
    end else if (unb < -1) begin
      sticky_o = 1'b1;
    end else if (unb == -1) begin
      rnd_o    = 1'b1;
      sticky_o = |man_f;
    end else if (unb <= MAN_W) begin
      wide     = {sig, {SIG_W{1'b0}}} >> (MAN_W - unb);
      int_o    = OUT_W'(wide[2*SIG_W-1:SIG_W]);
      rnd_o    = wide[SIG_W-1];
      sticky_o = |wide[SIG_W-2:0];
    end else if (unb < OUT_W) begin
      int_o = OUT_W'(sig) << (unb - MAN_W);
    end else begin
      huge_o = 1'b1;
    end
  end
endmodule

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
// Applies the rounding increment, range check per width and sentinel substitution.
module f2i_round
  import f2i_pkg::*;
#(
  parameter int OUT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  rnd_op_e           op_i,
  input  logic              long_i,
  input  logic              sign_i,
  input  logic              special_i,
  input  logic              huge_i,
  input  logic [OUT_W-1:0]  int_i,
  input  logic              rnd_i,
  input  logic              sticky_i,
  output logic [OUT_W-1:0]  value_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int LANES = 2;

  logic             inc, frac_nz;
  logic [OUT_W:0]   mag;
  logic [OUT_W-1:0] neg;
  logic [LANES-1:0] lane_ovf;
  logic [OUT_W-1:0] lane_val  [LANES];
  logic [OUT_W-1:0] lane_sent [LANES];
  logic             ovf, inv;

  assign frac_nz = rnd_i | sticky_i;

  always_comb begin
    unique case (op_i)
      OP_TRUNC: inc = 1'b0;
      OP_NEAR:  inc = rnd_i & (sticky_i | int_i[0]);
      OP_FLOOR: inc = sign_i & frac_nz;
      OP_CEIL:  inc = ~sign_i & frac_nz;
      default:  inc = 1'b0;
    endcase
  end

  assign mag = {1'b0, int_i} + {{OUT_W{1'b0}}, inc};
  assign neg = sign_i ? (~mag[OUT_W-1:0] + 1'b1) : mag[OUT_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : OUT_W;
    logic [OUT_W:0] lim;
    // negative side reaches one further than positive side
    assign lim = ({{OUT_W{1'b0}}, 1'b1} << (LW - 1)) - {{OUT_W{1'b0}}, ~sign_i};
    assign lane_ovf[g]  = huge_i | (mag > lim);
    assign lane_sent[g] = OUT_W'({1'b0, {(LW-1){1'b1}}});
    if (LW < OUT_W) begin : g_ext
      assign lane_val[g] = {{(OUT_W-LW){neg[LW-1]}}, neg[LW-1:0]};
    end else begin : g_full
      assign lane_val[g] = neg;
    end
  end

  assign ovf = ~special_i & lane_ovf[long_i];
  assign inv = special_i | ovf;

  always_comb begin
    flags_o          = '0;
    flags_o[FLAG_NV] = inv;
    flags_o[FLAG_OF] = ovf;
    flags_o[FLAG_UF] = 1'b0;  // a nonzero integer is never below the smallest normal
    flags_o[FLAG_NX] = ~special_i & ~huge_i & ~ovf & frac_nz;
  end

  assign value_o = inv ? lane_sent[long_i] : lane_val[long_i];
endmodule

// File: rtl/f2i_conv.sv
`timescale 1ns/1ps
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int EXP_W_P    = EXP_W,
  parameter int MAN_W_P    = MAN_W,
  parameter int OUT_W_P    = OUT_W,
  parameter int NARROW_W_P = NARROW_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [EXP_W_P+MAN_W_P:0] operand_i,
  input  logic [1:0]               op_i,
  input  logic                     long_i,
  input  logic                     flag_we_i,
  input  logic [FLAG_W-1:0]        flag_wdata_i,
  output logic                     valid_o,
  output logic [OUT_W_P-1:0]       result_o,
  output logic [FLAG_W-1:0]        flags_o
);
  logic               sign, special, huge, rnd, sticky;
  logic [OUT_W_P-1:0] int_mag, value;
  logic [FLAG_W-1:0]  new_fl;
  logic               valid_q;
  logic [OUT_W_P-1:0] result_q;
  logic [FLAG_W-1:0]  flags_q;

  f2i_align #(.EXP_W(EXP_W_P), .MAN_W(MAN_W_P), .OUT_W(OUT_W_P)) u_align (
    .operand_i (operand_i),
    .sign_o    (sign),
    .special_o (special),
    .huge_o    (huge),
    .int_o     (int_mag),
    .rnd_o     (rnd),
    .sticky_o  (sticky)
  );

  f2i_round #(.OUT_W(OUT_W_P), .NARROW_W(NARROW_W_P)) u_round (
    .op_i      (rnd_op_e'(op_i)),
    .long_i    (long_i),
    .sign_i    (sign),
    .special_i (special),
    .huge_i    (huge),
    .int_i     (int_mag),
    .rnd_i     (rnd),
    .sticky_i  (sticky),
    .value_o   (value),
    .flags_o   (new_fl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) result_q <= value;
      if (flag_we_i || valid_i)
        flags_q <= (flag_we_i ? flag_wdata_i : flags_q) | (valid_i ? new_fl : '0);
    end
  end

  assign valid_o  = valid_q;
  assign result_o = result_q;
  assign flags_o  = flags_q;

  p_valid_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_special_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (&operand_i[MAN_W_P +: EXP_W_P]) |=> flags_o[FLAG_NV] &&
    result_o == ($past(long_i) ? {1'b0, {(OUT_W_P-1){1'b1}}}
                               : OUT_W_P'({1'b0, {(NARROW_W_P-1){1'b1}}})));
  p_ovf_inv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && new_fl[FLAG_OF] |=> flags_o[FLAG_OF] && flags_o[FLAG_NV]);
  p_no_unf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> flags_o[FLAG_UF] == $past(flags_o[FLAG_UF]));
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> (flags_o | $past(flags_o)) == flags_o);
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
endmodule

// File: tb/f2i_conv_bench.sv
`timescale 1ns/1ps
module f2i_conv_bench;
  localparam real CLK_PERIOD = 5.0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [1:0]  op_i = '0;
  logic        long_i = 1'b0;
  logic        flag_we_i = 1'b0;
  logic [3:0]  flag_wdata_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_flags = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  f2i_conv u_f2i_conv (
    .clk_i, .rst_ni, .valid_i, .operand_i, .op_i, .long_i,
    .flag_we_i, .flag_wdata_i, .valid_o, .result_o, .flags_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (operand %h op %0d long %0b)",
               req, act, exp, operand_i, op_i, long_i);
    end
  endtask

  function automatic void model(input logic [31:0] x, input logic [1:0] op, input logic lng,
                                output logic [63:0] res, output logic [3:0] fl);
    int   ei;
    real  mag, v, r, fl_v, d, lim;
    logic ovf;
    ei = int'(x[30:23]);
    fl = '0;
    if (ei == 255) begin
      fl[3] = 1'b1;
      res = lng ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
      return;
    end
    if (ei == 0) mag = real'(x[22:0]) * (2.0 ** (-149));
    else         mag = real'({1'b1, x[22:0]}) * (2.0 ** (ei - 150));
    v = x[31] ? -mag : mag;
    case (op)
      2'd0: r = x[31] ? -$floor(mag) : $floor(mag);
      2'd1: begin
        fl_v = $floor(v);
        d = v - fl_v;
        if (d > 0.5)      r = fl_v + 1.0;
        else if (d < 0.5) r = fl_v;
        else              r = ($floor(fl_v / 2.0) * 2.0 == fl_v) ? fl_v : fl_v + 1.0;
      end
      2'd2: r = $floor(v);
      default: r = $ceil(v);
    endcase
    lim = 2.0 ** (lng ? 63 : 31);
    ovf = (r >= lim) || (r < -lim);
    if (ovf) begin
      fl[3] = 1'b1;
      fl[2] = 1'b1;
      res = lng ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
    end else begin
      fl[0] = (r != v);
      res = 64'(longint'(r));
    end
  endfunction

  // one conversion, optionally with a same-cycle flag write
  task automatic conv(input logic [31:0] x, input logic [1:0] op, input logic lng,
                      input string req, input logic we = 1'b0, input logic [3:0] wd = '0);
    logic [63:0] er;
    logic [3:0]  ef;
    @(negedge clk_i);
    operand_i = x; op_i = op; long_i = lng; valid_i = 1'b1;
    flag_we_i = we; flag_wdata_i = wd;
    model(x, op, lng, er, ef);
    exp_flags = (we ? wd : exp_flags) | ef;
    @(negedge clk_i);
    valid_i = 1'b0; flag_we_i = 1'b0;
    check("R1 valid pulse", 64'(valid_o), 64'd1);
    check({req, " result"}, result_o, er);
    check({req, " flags"}, 64'(flags_o), 64'(exp_flags));
  endtask

  task automatic write_flags(input logic [3:0] wd);
    @(negedge clk_i);
    flag_we_i = 1'b1; flag_wdata_i = wd;
    exp_flags = wd;
    @(negedge clk_i);
    flag_we_i = 1'b0;
    check("R9 flag write", 64'(flags_o), 64'(wd));
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin : main
    logic [63:0] held;
    void'($urandom(32'h5EED_0F2A));
    repeat (3) @(negedge clk_i);
    check("R10 reset valid", 64'(valid_o), 64'd0);
    check("R10 reset result", result_o, 64'd0);
    check("R10 reset flags", 64'(flags_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle valid", 64'(valid_o), 64'd0);

    // R3 ties to even
    conv(32'h4020_0000, 2'd1, 1'b0, "R3 2.5");
    conv(32'h4060_0000, 2'd1, 1'b0, "R3 3.5");
    conv(32'hC020_0000, 2'd1, 1'b1, "R3 -2.5");
    conv(32'h3F00_0000, 2'd1, 1'b0, "R3 0.5");
    conv(32'h3FC0_0000, 2'd1, 1'b1, "R3 1.5");
    // R2 truncate
    conv(32'hBFE0_0000, 2'd0, 1'b0, "R2 -1.75");
    write_flags(4'b0000);
    conv(32'h4000_0000, 2'd0, 1'b0, "R7 exact 2.0");
    // R4 floor / ceiling
    conv(32'hBFA0_0000, 2'd2, 1'b0, "R4 floor -1.25");
    conv(32'h3FA0_0000, 2'd3, 1'b1, "R4 ceil 1.25");
    conv(32'hBE80_0000, 2'd3, 1'b0, "R4 ceil -0.25");
    // R9 sticky: exact conversion keeps inexact flag
    conv(32'h4040_0000, 2'd1, 1'b0, "R9 sticky keep");
    // R8 subnormal
    write_flags(4'b0000);
    conv(32'h0000_0001, 2'd3, 1'b0, "R8 subnormal ceil");
    conv(32'h8000_0001, 2'd2, 1'b1, "R8 subnormal floor");
    conv(32'h0000_0001, 2'd0, 1'b0, "R8 subnormal trunc");
    // R6 range edges
    write_flags(4'b0000);
    conv(32'hCF00_0000, 2'd0, 1'b0, "R6 -2^31 word");
    conv(32'h4F00_0000, 2'd0, 1'b0, "R6 2^31 word");
    write_flags(4'b0000);
    conv(32'h4F00_0000, 2'd2, 1'b1, "R11 2^31 long");
    conv(32'hDF00_0000, 2'd3, 1'b1, "R6 -2^63 long");
    conv(32'h5F00_0000, 2'd1, 1'b1, "R6 2^63 long");
    conv(32'hC0A0_0000, 2'd0, 1'b0, "R11 sign extend -5");
    // R5 specials
    write_flags(4'b0000);
    conv(32'h7FC0_0000, 2'd0, 1'b1, "R5 NaN long");
    write_flags(4'b0000);
    conv(32'h7F80_0000, 2'd1, 1'b0, "R5 +inf word");
    conv(32'hFF80_0000, 2'd3, 1'b1, "R5 -inf long");
    // R9 write and conversion in same cycle
    conv(32'h3FA0_0000, 2'd1, 1'b0, "R9 clear with inexact", 1'b1, 4'b0000);
    conv(32'h7FC0_0000, 2'd2, 1'b0, "R9 write with NaN", 1'b1, 4'b0110);
    // R12 hold
    held = result_o;
    @(negedge clk_i);
    operand_i = 32'h4120_0000; op_i = 2'd3; long_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R12 result held", result_o, held);
    check("R1 no pulse while idle", 64'(valid_o), 64'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] x;
      logic [7:0]  e;
      logic        we;
      int          cls;
      cls = int'($urandom % 16);
      if (cls == 0)      e = 8'hFF;
      else if (cls == 1) e = 8'h00;
      else if (cls < 7)  e = 8'(124 + $urandom % 8);
      else               e = 8'(100 + $urandom % 100);
      x = {1'($urandom), e, 23'($urandom)};
      if ($urandom % 3 == 0) x[19:0] = '0;
      we = ($urandom % 10 == 0);
      conv(x, 2'($urandom), 1'($urandom), "R2 R3 R4 R6 R7 random", we, 4'($urandom));
    end
    finish_run();
  end
endmodule